// File: doc/BRIEF.md
# Shared Fast-Clock Gating Controller

This block decides, for a group of eight pixel channels that draw on one shared fast oscillator, when that oscillator runs and which fine counters may count its cycles. The first hit seen in the group turns the oscillator on and opens that pixel's counter gate. The system clock domain then issues a common stop at its next rising edge. The stop crosses into the fast domain and closes every open gate on the same fast edge. The oscillator enable drops one fast cycle later. A pixel hit while the oscillator is already running joins the measurement. Its gate opens from its own hit, so its counter holds only the fast cycles between that hit and the common stop.

Each pixel input first passes through a four-way source selector: the detector hit or one of three shared test lines. The selected hit is brought into the fast clock domain through a two-stage synchronizer. The gate acts on its rising edge only. All gate and enable changes happen on fast clock edges. The only signals that cross between the two clocks are single bits passed through synchronizers. So no counter gate ever changes on an edge that both clocks share. A hit that is detected after the stop has reached the fast domain is held back. It is not merged into the ending measurement but starts a fresh one once the stop handshake has cleared.

Top module: `oscg_group`

## Requirements
- R1: While reset is high and on the first cycles after it falls with all hits low, `osc_en` and every bit of `cnt_en` are 0.
- R2: From idle, a selected hit that rises just before a fast clock edge makes `osc_en` and that pixel's `cnt_en` bit rise together on the third fast rising edge, counting that edge as the first. Pixels hit together open together.
- R3: A pixel hit while the group is measuring opens its own gate with the same three-edge latency. Gates already open are left unchanged, and every open gate stays open until the common stop.
- R4: An open gate implies `osc_en` is high. `osc_en` falls exactly one fast cycle after the gates have closed.
- R5: All open gates close on the same fast edge. This happens after the stop has been raised at a system clock rising edge and passed through the synchronizers, and falls between two and four system clock periods after the gates opened.
- R6: A hit detected after the stop has reached the fast domain opens no gate in the ending measurement. Once `osc_en` has been low and the stop handshake has cleared, it starts a new measurement with only that pixel's gate open.
- R7: Gates act on rising edges of the selected hit. A hit held high after its measurement has ended starts no new measurement. Lowering and raising it again starts one.
- R8: Per pixel i, `src_sel[2i+1:2i]` chooses the source: 0 the detector hit `hit_det[i]`, 1 `test_a`, 2 `test_b`, 3 `test_c`.
- R9: Sources that a pixel's select does not choose have no effect on that pixel's gate or on `osc_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Free-running fast clock (oscillator replica) |
| clk_sys | input | 1 | System clock that defines the common stop |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| hit_det | input | 8 | Asynchronous detector hit, one per pixel |
| test_a | input | 1 | Shared test stimulus A |
| test_b | input | 1 | Shared test stimulus B |
| test_c | input | 1 | Shared test stimulus C |
| src_sel | input | 16 | Per-pixel 2-bit source select, pixel i at bits [2i+1:2i] |
| osc_en | output | 1 | Enable for the shared fast oscillator |
| cnt_en | output | 8 | Per-pixel fine-counter enable (gated fast clock) |

## Verification
The assertions assume three things about the inputs. Each selected hit stays high for at least two fast cycles, so the synchronizer catches it. A pixel's source select does not change while its selected source is high. Reset spans several edges of both clocks. The stimulus changes inputs only at fast falling edges and holds every hit for many fast cycles. It switches selects only while all sources are low, and holds reset for several system periods. The system clock is offset from the fast clock, so the crossings see realistic phases without sharing an edge.

// File: rtl/oscg_pkg.sv
package oscg_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_DET = 2'd0,
        SRC_TA  = 2'd1,
        SRC_TB  = 2'd2,
        SRC_TC  = 2'd3
    } src_sel_e;

    typedef enum logic [1:0] {
        F_IDLE  = 2'd0,
        F_RUN   = 2'd1,
        F_DRAIN = 2'd2
    } fast_state_e;

    typedef struct packed {
        logic det;
        logic ta;
        logic tb;
        logic tc;
    } src_bundle_t;

    function automatic logic pick_src(input src_bundle_t b, input src_sel_e s);
        logic r;
        case (s)
            SRC_DET: r = b.det;
            SRC_TA:  r = b.ta;
            SRC_TB:  r = b.tb;
            default: r = b.tc;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/oscg_src_mux.sv
module oscg_src_mux
    import oscg_pkg::*;
#(
    parameter int NUM_PIX = 8,
    localparam int SELV_W = NUM_PIX * SEL_W
) (
    input  logic [NUM_PIX-1:0] hit_det,
    input  logic               test_a,
    input  logic               test_b,
    input  logic               test_c,
    input  logic [SELV_W-1:0]  src_sel,
    output logic [NUM_PIX-1:0] hit_sel
);

    for (genvar i = 0; i < NUM_PIX; i++) begin : g_mux
        src_bundle_t bundle;
        assign bundle = '{det: hit_det[i], ta: test_a, tb: test_b, tc: test_c};
        assign hit_sel[i] = pick_src(bundle, src_sel_e'(src_sel[i*SEL_W +: SEL_W]));
    end

endmodule

// File: rtl/oscg_pixel_sync.sv
module oscg_pixel_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hit_async,
    output logic hit_edge
);

    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-1:0], hit_async};
    end

    assign hit_edge = chain_q[STAGES-1] & ~chain_q[STAGES];

    // a level change yields at most one edge pulse
    assert_single_edge_R7: assert property (@(posedge clk) disable iff (rst)
        hit_edge |=> !hit_edge);

endmodule

// File: rtl/oscg_stop_gen.sv
module oscg_stop_gen #(
    parameter int STAGES = 2
) (
    input  logic clk_sys,
    input  logic rst,
    input  logic osc_en_async,
    output logic stop_req
);

    logic [STAGES-1:0] run_chain_q;
    logic              run_s;
    logic              stop_q;

    always_ff @(posedge clk_sys) begin
        if (rst) run_chain_q <= '0;
        else     run_chain_q <= {run_chain_q[STAGES-2:0], osc_en_async};
    end

    assign run_s = run_chain_q[STAGES-1];

    always_ff @(posedge clk_sys) begin
        if (rst)                  stop_q <= 1'b0;
        else if (!stop_q && run_s) stop_q <= 1'b1;
        else if (stop_q && !run_s) stop_q <= 1'b0;
    end

    assign stop_req = stop_q;

    assert_stop_hold_R5: assert property (@(posedge clk_sys) disable iff (rst)
        (stop_q && run_s) |=> stop_q);

    assert_stop_needs_run_R5: assert property (@(posedge clk_sys) disable iff (rst)
        (!stop_q && !run_s) |=> !stop_q);

endmodule

// File: rtl/oscg_fast_ctrl.sv
module oscg_fast_ctrl
    import oscg_pkg::*;
#(
    parameter int NUM_PIX = 8,
    parameter int STAGES  = 2
) (
    input  logic               clk_fast,
    input  logic               rst,
    input  logic [NUM_PIX-1:0] hit_edge,
    input  logic               stop_async,
    output logic               osc_en,
    output logic [NUM_PIX-1:0] gate
);

    logic [STAGES-1:0] stop_chain_q;
    logic              stop_s;
    fast_state_e       st_q, st_d;
    logic [NUM_PIX-1:0] gate_q, gate_d, arm_q, arm_d;
    logic              osc_q, osc_d;

    always_ff @(posedge clk_fast) begin
        if (rst) stop_chain_q <= '0;
        else     stop_chain_q <= {stop_chain_q[STAGES-2:0], stop_async};
    end

    assign stop_s = stop_chain_q[STAGES-1];

    always_comb begin
        st_d   = st_q;
        gate_d = gate_q;
        arm_d  = arm_q;
        osc_d  = osc_q;
        unique case (st_q)
            F_IDLE: begin
                if (|(arm_q | hit_edge)) begin
                    st_d   = F_RUN;
                    gate_d = arm_q | hit_edge;
                    arm_d  = '0;
                    osc_d  = 1'b1;
                end
            end
            F_RUN: begin
                if (stop_s) begin
                    st_d   = F_DRAIN;
                    gate_d = '0;
                    arm_d  = arm_q | hit_edge;
                end else begin
                    gate_d = gate_q | hit_edge;
                end
            end
            F_DRAIN: begin
                osc_d = 1'b0;
                arm_d = arm_q | hit_edge;
                if (!stop_s && !osc_q) st_d = F_IDLE;
            end
            default: begin
                st_d   = F_IDLE;
                gate_d = '0;
                osc_d  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_fast) begin
        if (rst) begin
            st_q   <= F_IDLE;
            gate_q <= '0;
            arm_q  <= '0;
            osc_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            gate_q <= gate_d;
            arm_q  <= arm_d;
            osc_q  <= osc_d;
        end
    end

    assign osc_en = osc_q;
    assign gate   = gate_q;

    assert_gate_needs_osc_R4: assert property (@(posedge clk_fast) disable iff (rst)
        (|gate_q) |-> osc_q);

    assert_osc_falls_after_gates_R4: assert property (@(posedge clk_fast) disable iff (rst)
        $fell(osc_q) |-> ($past(gate_q) == '0));

    assert_start_with_gate_R2: assert property (@(posedge clk_fast) disable iff (rst)
        $rose(osc_q) |-> (|gate_q));

    assert_gates_hold_R3: assert property (@(posedge clk_fast) disable iff (rst)
        (st_q == F_RUN && !stop_s) |=> ((gate_q & $past(gate_q)) == $past(gate_q)));

    assert_stop_closes_all_R5: assert property (@(posedge clk_fast) disable iff (rst)
        (st_q == F_RUN && stop_s) |=> (gate_q == '0));

    assert_drain_no_merge_R6: assert property (@(posedge clk_fast) disable iff (rst)
        (st_q == F_DRAIN) |-> (gate_q == '0));

endmodule

// File: rtl/oscg_group.sv
module oscg_group
    import oscg_pkg::*;
#(
    parameter int NUM_PIX     = 8,
    parameter int SYNC_STAGES = 2,
    localparam int SELV_W     = NUM_PIX * SEL_W
) (
    input  logic               clk_fast,
    input  logic               clk_sys,
    input  logic               rst,
    input  logic [NUM_PIX-1:0] hit_det,
    input  logic               test_a,
    input  logic               test_b,
    input  logic               test_c,
    input  logic [SELV_W-1:0]  src_sel,
    output logic               osc_en,
    output logic [NUM_PIX-1:0] cnt_en
);

    logic [NUM_PIX-1:0] hit_sel;
    logic [NUM_PIX-1:0] hit_edge;
    logic               stop_req;

    oscg_src_mux #(.NUM_PIX(NUM_PIX)) u_mux (
        .hit_det (hit_det),
        .test_a  (test_a),
        .test_b  (test_b),
        .test_c  (test_c),
        .src_sel (src_sel),
        .hit_sel (hit_sel)
    );

    for (genvar i = 0; i < NUM_PIX; i++) begin : g_pix
        oscg_pixel_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk       (clk_fast),
            .rst       (rst),
            .hit_async (hit_sel[i]),
            .hit_edge  (hit_edge[i])
        );
    end

    oscg_stop_gen #(.STAGES(SYNC_STAGES)) u_stop (
        .clk_sys      (clk_sys),
        .rst          (rst),
        .osc_en_async (osc_en),
        .stop_req     (stop_req)
    );

    oscg_fast_ctrl #(.NUM_PIX(NUM_PIX), .STAGES(SYNC_STAGES)) u_ctrl (
        .clk_fast   (clk_fast),
        .rst        (rst),
        .hit_edge   (hit_edge),
        .stop_async (stop_req),
        .osc_en     (osc_en),
        .gate       (cnt_en)
    );

endmodule

// File: tb/sim_oscg_group.sv
module sim_oscg_group;

    logic        clk_fast = 1'b0;
    logic        clk_sys  = 1'b0;
    logic        rst      = 1'b1;
    logic [7:0]  hit_det  = '0;
    logic        test_a   = 1'b0;
    logic        test_b   = 1'b0;
    logic        test_c   = 1'b0;
    logic [15:0] src_sel  = '0;
    logic        osc_en;
    logic [7:0]  cnt_en;

    int n_chk  = 0;
    int n_fail = 0;
    int n_viol = 0;

    always #5 clk_fast = ~clk_fast;
    initial begin
        #2;
        forever #40 clk_sys = ~clk_sys;
    end

    oscg_group u0 (
        .clk_fast (clk_fast),
        .clk_sys  (clk_sys),
        .rst      (rst),
        .hit_det  (hit_det),
        .test_a   (test_a),
        .test_b   (test_b),
        .test_c   (test_c),
        .src_sel  (src_sel),
        .osc_en   (osc_en),
        .cnt_en   (cnt_en)
    );

    typedef struct packed {
        logic [15:0] sel;
        logic [7:0]  det;
        logic [2:0]  tst;   // {c, b, a}
        logic [7:0]  exp;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{16'h0000, 8'h01, 3'b000, 8'h01},
        '{16'h0000, 8'hA5, 3'b000, 8'hA5},
        '{16'h5555, 8'hFF, 3'b000, 8'h00},
        '{16'h5555, 8'h00, 3'b001, 8'hFF},
        '{16'h0039, 8'h08, 3'b100, 8'h0C},
        '{16'hFFFF, 8'hFF, 3'b010, 8'h00},
        '{16'hAAAA, 8'h00, 3'b010, 8'hFF}
    };

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk_fast);
    endtask

    task automatic wait_idle();
        int quiet = 0;
        for (int k = 0; k < 3000 && quiet < 60; k++) begin
            @(negedge clk_fast);
            if (osc_en) quiet = 0;
            else        quiet++;
        end
    endtask

    always @(negedge clk_fast)
        if (!rst && cnt_en != 8'h00 && !osc_en) n_viol++;

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        cyc(3);
        chk(osc_en == 1'b0 && cnt_en == 8'h00, "R1 during reset", {osc_en, cnt_en}, 0);
        cyc(40);
        rst = 1'b0;
        cyc(5);
        chk(osc_en == 1'b0 && cnt_en == 8'h00, "R1 after reset", {osc_en, cnt_en}, 0);

        // R2 R8 R9: table of source selects and hit patterns
        foreach (VECS[v]) begin
            src_sel = VECS[v].sel;
            cyc(3);
            hit_det = VECS[v].det;
            {test_c, test_b, test_a} = VECS[v].tst;
            cyc(2);
            chk(cnt_en == 8'h00 && !osc_en, "R2 not before third edge", cnt_en, 0);
            cyc(1);
            chk(cnt_en == VECS[v].exp, "R8 R9 gate pattern", cnt_en, VECS[v].exp);
            chk(osc_en == (VECS[v].exp != 8'h00), "R2 R9 osc enable", osc_en, (VECS[v].exp != 8'h00));
            hit_det = '0;
            {test_c, test_b, test_a} = 3'b000;
            wait_idle();
        end
        src_sel = '0;
        cyc(3);

        // R3: later hit joins a running measurement
        hit_det[0] = 1'b1;
        cyc(3);
        chk(cnt_en == 8'h01, "R3 first opens", cnt_en, 8'h01);
        cyc(5);
        hit_det[5] = 1'b1;
        cyc(2);
        chk(cnt_en == 8'h01, "R3 joiner not early", cnt_en, 8'h01);
        cyc(1);
        chk(cnt_en == 8'h21 && osc_en, "R3 joiner opens", cnt_en, 8'h21);
        for (int k = 0; k < 500 && cnt_en == 8'h21; k++) cyc(1);
        chk(cnt_en == 8'h00, "R5 common stop", cnt_en, 8'h00);
        hit_det = '0;
        wait_idle();

        // R5 R4: open duration and enable drop
        begin
            int len = 0;
            hit_det[2] = 1'b1;
            cyc(3);
            while (cnt_en[2] && len < 1000) begin
                len++;
                cyc(1);
            end
            chk(len >= 16 && len <= 32, "R5 open length", len, 24);
            chk(osc_en == 1'b1, "R4 osc still high when gates close", osc_en, 1);
            cyc(1);
            chk(osc_en == 1'b0, "R4 osc drops one cycle later", osc_en, 0);
        end

        // R7: held hit does not restart, re-raised hit does
        begin
            logic seen = 1'b0;
            for (int k = 0; k < 150; k++) begin
                cyc(1);
                if (osc_en) seen = 1'b1;
            end
            chk(!seen, "R7 held hit ignored", seen, 0);
        end
        hit_det[2] = 1'b0;
        cyc(4);
        hit_det[2] = 1'b1;
        cyc(3);
        chk(cnt_en == 8'h04 && osc_en, "R7 re-raised hit restarts", cnt_en, 8'h04);
        hit_det = '0;
        wait_idle();

        // R6: hit during drain starts a new measurement
        hit_det[0] = 1'b1;
        cyc(3);
        for (int k = 0; k < 500 && cnt_en != 8'h00; k++) cyc(1);
        hit_det[3] = 1'b1;
        cyc(1);
        chk(osc_en == 1'b0 && cnt_en == 8'h00, "R6 not merged", {osc_en, cnt_en}, 0);
        begin
            logic restarted = 1'b0;
            for (int k = 0; k < 600 && !restarted; k++) begin
                cyc(1);
                if (osc_en) restarted = 1'b1;
            end
            chk(restarted, "R6 new measurement starts", restarted, 1);
            chk(cnt_en == 8'h08, "R6 only late pixel open", cnt_en, 8'h08);
        end
        hit_det = '0;
        wait_idle();

        chk(n_viol == 0, "R4 gate without osc", n_viol, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule